// File: doc/BRIEF.md
# Pattern-Indexed Waveform Table

This block is the per-channel waveform store of a digital test channel. Every cycle a pattern byte arrives with a qualifying valid flag. The byte selects one of 256 waveform entries. Each entry holds four events, and each event pairs a 22-bit delay with a 4-bit event code, so sixteen event codes are possible. One clock after a qualified byte, the block presents the four event descriptors of the selected entry, each with its own enable, to the edge timing logic downstream.

The same byte is also split into pin-state and timeset fields for the formatter. In single-rate mode the split gives one 3-bit pin state and a 5-bit timeset index, which selects one of 32 timesets. In dual-rate mode it gives two 3-bit pin states and a 2-bit timeset index, which selects one of 4 timesets. A separate host port writes and reads single events by word address. The host port runs at the same time as pattern lookups and does not stall them. When the valid flag is low, the byte is ignored and nothing is issued.

Top module: `wave_lut`

## Requirements
- R1: While reset is asserted, every output is zero: enables, delays, codes, pin states, timeset and host read data.
- R2: A host write stores `host_wdata_i` at word address `host_addr_i`. Address bits [9:2] give the entry and bits [1:0] give the event. Within a word, bits [21:0] are the delay and bits [25:22] are the code. The host read data is registered: one cycle after the address is presented, it shows that word.
- R3: One cycle after `pat_valid_i` is high with byte p, event k of entry p appears on `evt_delay_o[22k+21:22k]` and `evt_code_o[4k+3:4k]`.
- R4: One cycle after `pat_valid_i` is high, all four bits of `evt_en_o` are high.
- R5: One cycle after `pat_valid_i` is low, `evt_en_o`, `evt_delay_o`, `evt_code_o`, `state0_o`, `state1_o` and `tset_o` are all zero, whatever `pat_i` holds.
- R6: With `dual_rate_i` = 0 and valid high, one cycle later `state0_o` = p[2:0], `tset_o` = p[7:3] and `state1_o` = 0.
- R7: With `dual_rate_i` = 1 and valid high, one cycle later `state0_o` = p[2:0], `state1_o` = p[5:3] and `tset_o` = {3'b000, p[7:6]}.
- R8: If a host write hits an event of the entry that a valid lookup reads in the same cycle, the lookup returns the contents from before the write. A later lookup returns the new contents.
- R9: A host read of the word being written in the same cycle returns the contents from before the write.
- R10: Host writes and reads to any entry, made while lookups run, do not delay or corrupt the lookup results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_rate_i | input | 1 | 0: single-rate field split, 1: dual-rate field split |
| pat_valid_i | input | 1 | Qualifies `pat_i` |
| pat_i | input | 8 | Pattern byte, entry index |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 10 | Host word address {entry, event} |
| host_wdata_i | input | 26 | Host write word {code, delay} |
| host_rdata_o | output | 26 | Registered host read word |
| evt_en_o | output | 4 | Per-event enable |
| evt_delay_o | output | 88 | Four 22-bit delays, event 0 lowest |
| evt_code_o | output | 16 | Four 4-bit codes, event 0 lowest |
| state0_o | output | 3 | First pin state |
| state1_o | output | 3 | Second pin state (dual-rate only) |
| tset_o | output | 5 | Timeset index |

## Verification
The bench aims at same-cycle collisions between the host port and the lookup port. A design that forwards new write data into the read would show the new word one cycle early, on the lookup outputs or on the host read data. Idle cycles are driven with non-zero pattern bytes. A design that let the byte through would show stale descriptors or fields while the enables are low. The mode input is toggled from cycle to cycle, so a design that picks the wrong bit slice, or leaves high timeset bits set in dual-rate mode, shows field mismatches. Events are written one by one to every entry, so any swapped lane or misplaced event would show in the lookups.

// File: rtl/wave_lut_pkg.sv
package wave_lut_pkg;
  localparam int DEF_PAT_W   = 8;
  localparam int DEF_EVT_N   = 4;
  localparam int DEF_DLY_W   = 22;
  localparam int DEF_CODE_W  = 4;
  localparam int DEF_STATE_W = 3;

  typedef enum logic {
    RATE_SINGLE = 1'b0,
    RATE_DUAL   = 1'b1
  } rate_e;
endpackage

// File: rtl/wave_lut_bank.sv
module wave_lut_bank #(
  parameter int AW = 8,
  parameter int DW = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pat_re_i,
  input  logic [AW-1:0] pat_addr_i,
  output logic [DW-1:0] pat_q_o,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_q_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (host_we_i) mem[host_addr_i] <= host_wdata_i;
  end

  // both read ports sample before the write lands: old data on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q_o  <= '0;
      host_q_o <= '0;
    end else begin
      if (pat_re_i) pat_q_o <= mem[pat_addr_i];
      host_q_o <= mem[host_addr_i];
    end
  end

  assert_lookup_old_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_re_i && host_we_i && host_addr_i == pat_addr_i) |=> pat_q_o == $past(mem[pat_addr_i]));

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i |=> mem[$past(host_addr_i)] == $past(host_wdata_i));

  assert_host_rdw_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i |=> host_q_o == $past(mem[host_addr_i]));
endmodule

// File: rtl/wave_lut_split.sv
module wave_lut_split
  import wave_lut_pkg::*;
#(
  parameter int PAT_W   = 8,
  parameter int STATE_W = 3,
  localparam int TSET_W = PAT_W - STATE_W
) (
  input  logic [PAT_W-1:0]   pat_i,
  input  rate_e              rate_i,
  output logic [STATE_W-1:0] st0_o,
  output logic [STATE_W-1:0] st1_o,
  output logic [TSET_W-1:0]  tset_o
);
  localparam int DUAL_TS_W = PAT_W - 2 * STATE_W;

  always_comb begin
    st0_o = pat_i[STATE_W-1:0];
    if (rate_i == RATE_DUAL) begin
      st1_o  = pat_i[2*STATE_W-1:STATE_W];
      tset_o = {{(TSET_W - DUAL_TS_W){1'b0}}, pat_i[PAT_W-1:2*STATE_W]};
    end else begin
      st1_o  = '0;
      tset_o = pat_i[PAT_W-1:STATE_W];
    end
  end
endmodule

// File: rtl/wave_lut_gate.sv
module wave_lut_gate #(
  parameter int EVT_N  = 4,
  parameter int DLY_W  = 22,
  parameter int CODE_W = 4,
  localparam int EVT_W = DLY_W + CODE_W
) (
  input  logic                    valid_i,
  input  logic [EVT_N*EVT_W-1:0]  word_i,
  output logic [EVT_N-1:0]        en_o,
  output logic [EVT_N*DLY_W-1:0]  delay_o,
  output logic [EVT_N*CODE_W-1:0] code_o
);
  for (genvar k = 0; k < EVT_N; k++) begin : g_evt
    logic [EVT_W-1:0] w;
    assign w = word_i[k*EVT_W +: EVT_W];
    assign en_o[k]                  = valid_i;
    assign delay_o[k*DLY_W +: DLY_W]   = valid_i ? w[DLY_W-1:0] : '0;
    assign code_o[k*CODE_W +: CODE_W]  = valid_i ? w[EVT_W-1:DLY_W] : '0;
  end
endmodule

// File: rtl/wave_lut.sv
module wave_lut
  import wave_lut_pkg::*;
#(
  parameter int PAT_W   = DEF_PAT_W,
  parameter int EVT_N   = DEF_EVT_N,
  parameter int DLY_W   = DEF_DLY_W,
  parameter int CODE_W  = DEF_CODE_W,
  parameter int STATE_W = DEF_STATE_W,
  localparam int EVT_W   = DLY_W + CODE_W,
  localparam int SEL_W   = $clog2(EVT_N),
  localparam int HADDR_W = PAT_W + SEL_W,
  localparam int TSET_W  = PAT_W - STATE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dual_rate_i,
  input  logic                    pat_valid_i,
  input  logic [PAT_W-1:0]        pat_i,
  input  logic                    host_we_i,
  input  logic [HADDR_W-1:0]      host_addr_i,
  input  logic [EVT_W-1:0]        host_wdata_i,
  output logic [EVT_W-1:0]        host_rdata_o,
  output logic [EVT_N-1:0]        evt_en_o,
  output logic [EVT_N*DLY_W-1:0]  evt_delay_o,
  output logic [EVT_N*CODE_W-1:0] evt_code_o,
  output logic [STATE_W-1:0]      state0_o,
  output logic [STATE_W-1:0]      state1_o,
  output logic [TSET_W-1:0]       tset_o
);
  localparam int DUAL_TS_W = PAT_W - 2 * STATE_W;

  logic [SEL_W-1:0]       host_sel;
  logic [PAT_W-1:0]       host_ent;
  logic [SEL_W-1:0]       host_sel_q;
  logic                   valid_q;
  logic [EVT_N*EVT_W-1:0] pat_words;
  logic [EVT_W-1:0]       bank_hq [EVT_N];
  logic [STATE_W-1:0]     st0_d, st1_d;
  logic [TSET_W-1:0]      tset_d;

  assign host_sel = host_addr_i[SEL_W-1:0];
  assign host_ent = host_addr_i[HADDR_W-1:SEL_W];

  for (genvar k = 0; k < EVT_N; k++) begin : g_bank
    logic bank_we;
    assign bank_we = host_we_i && (host_sel == SEL_W'(k));
    wave_lut_bank #(.AW(PAT_W), .DW(EVT_W)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pat_re_i    (pat_valid_i),
      .pat_addr_i  (pat_i),
      .pat_q_o     (pat_words[k*EVT_W +: EVT_W]),
      .host_we_i   (bank_we),
      .host_addr_i (host_ent),
      .host_wdata_i(host_wdata_i),
      .host_q_o    (bank_hq[k])
    );
  end

  wave_lut_split #(.PAT_W(PAT_W), .STATE_W(STATE_W)) u_split (
    .pat_i (pat_i),
    .rate_i(rate_e'(dual_rate_i)),
    .st0_o (st0_d),
    .st1_o (st1_d),
    .tset_o(tset_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      host_sel_q <= '0;
      state0_o   <= '0;
      state1_o   <= '0;
      tset_o     <= '0;
    end else begin
      valid_q    <= pat_valid_i;
      host_sel_q <= host_sel;
      state0_o   <= pat_valid_i ? st0_d  : '0;
      state1_o   <= pat_valid_i ? st1_d  : '0;
      tset_o     <= pat_valid_i ? tset_d : '0;
    end
  end

  assign host_rdata_o = bank_hq[host_sel_q];

  wave_lut_gate #(.EVT_N(EVT_N), .DLY_W(DLY_W), .CODE_W(CODE_W)) u_gate (
    .valid_i(valid_q),
    .word_i (pat_words),
    .en_o   (evt_en_o),
    .delay_o(evt_delay_o),
    .code_o (evt_code_o)
  );

  assert_en_follows_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_valid_i |=> evt_en_o == '1);

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pat_valid_i |=> (evt_en_o == '0 && evt_delay_o == '0 && evt_code_o == '0
                      && state0_o == '0 && state1_o == '0 && tset_o == '0));

  assert_single_split_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_valid_i && !dual_rate_i) |=> (state1_o == '0
      && state0_o == $past(pat_i[STATE_W-1:0])
      && tset_o == $past(pat_i[PAT_W-1:STATE_W])));

  assert_dual_split_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_valid_i && dual_rate_i) |=> (state1_o == $past(pat_i[2*STATE_W-1:STATE_W])
      && tset_o == TSET_W'($past(pat_i[PAT_W-1:2*STATE_W]))
      && tset_o[TSET_W-1:DUAL_TS_W] == '0));
endmodule

// File: tb/tb_wave_lut.sv
module tb_wave_lut;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dual_rate_i = 1'b0;
  logic        pat_valid_i = 1'b0;
  logic [7:0]  pat_i = '0;
  logic        host_we_i = 1'b0;
  logic [9:0]  host_addr_i = '0;
  logic [25:0] host_wdata_i = '0;
  logic [25:0] host_rdata_o;
  logic [3:0]  evt_en_o;
  logic [87:0] evt_delay_o;
  logic [15:0] evt_code_o;
  logic [2:0]  state0_o, state1_o;
  logic [4:0]  tset_o;

  always #(CLK_P/2) clk_i = ~clk_i;

  wave_lut dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [25:0] mem_m [1024];
  logic [3:0]  x_en;
  logic [87:0] x_dly;
  logic [15:0] x_code;
  logic [2:0]  x_s0, x_s1;
  logic [4:0]  x_ts;
  logic [25:0] x_hrd;
  string tag_evt, tag_en, tag_fld, tag_hrd;

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(tag_en,  "evt_en",  128'(evt_en_o),    128'(x_en));
    chk(tag_evt, "delay",   128'(evt_delay_o), 128'(x_dly));
    chk(tag_evt, "code",    128'(evt_code_o),  128'(x_code));
    chk(tag_fld, "state0",  128'(state0_o),    128'(x_s0));
    chk(tag_fld, "state1",  128'(state1_o),    128'(x_s1));
    chk(tag_fld, "tset",    128'(tset_o),      128'(x_ts));
    chk(tag_hrd, "rdata",   128'(host_rdata_o), 128'(x_hrd));
  endtask

  logic [9:0] prev_waddr;
  bit         prev_we;

  // drive at negedge, model the next state, check at the following negedge
  task automatic cyc(bit v, logic [7:0] p, bit d, bit we, logic [9:0] a, logic [25:0] wd);
    bit coll;
    pat_valid_i = v; pat_i = p; dual_rate_i = d;
    host_we_i = we; host_addr_i = a; host_wdata_i = wd;
    coll = we && v && (a[9:2] == p);
    x_en = v ? 4'hf : 4'h0;
    x_dly = '0; x_code = '0; x_s0 = '0; x_s1 = '0; x_ts = '0;
    if (v) begin
      for (int k = 0; k < 4; k++) begin
        x_dly[22*k +: 22] = mem_m[{p, 2'(k)}][21:0];
        x_code[4*k +: 4]  = mem_m[{p, 2'(k)}][25:22];
      end
      x_s0 = p[2:0];
      if (d) begin x_s1 = p[5:3]; x_ts = {3'b000, p[7:6]}; end
      else   begin x_s1 = '0;     x_ts = p[7:3]; end
    end
    x_hrd = mem_m[a];
    tag_en  = v ? "R4" : "R5";
    tag_evt = !v ? "R5" : coll ? "R8" : we ? "R10" : "R3";
    tag_fld = !v ? "R5" : d ? "R7" : "R6";
    tag_hrd = we ? "R9" : "R2";
    if (we) mem_m[a] = wd;
    prev_we = we; prev_waddr = a;
    @(negedge clk_i);
    compare_all();
  endtask

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk_i);
    chk("R1", "evt_en", 128'(evt_en_o), 128'(0));
    chk("R1", "delay",  128'(evt_delay_o), 128'(0));
    chk("R1", "code",   128'(evt_code_o), 128'(0));
    chk("R1", "fields", 128'({state0_o, state1_o, tset_o}), 128'(0));
    chk("R1", "rdata",  128'(host_rdata_o), 128'(0));
    rst_ni = 1'b1;

    // fill every event of every entry through the host port (R2)
    for (int i = 0; i < 1024; i++)
      cyc(1'b0, 8'(i * 7 + 3), 1'b0, 1'b1, 10'(i), 26'(i * 32'h9E3779B1 ^ (i << 13)));

    // read back a spread of words, pattern idle with noisy bytes (R2, R5)
    for (int i = 0; i < 64; i++)
      cyc(1'b0, 8'($urandom), 1'($urandom), 1'b0, 10'(i * 16 + 5), '0);

    // directed collisions: lookup entry being written (R8), then re-read
    for (int i = 0; i < 24; i++) begin
      logic [7:0] p = 8'($urandom);
      logic [9:0] a = {p, 2'(i)};
      cyc(1'b1, p, 1'(i), 1'b1, a, 26'($urandom));
      cyc(1'b1, p, 1'(i + 1), 1'b0, a, '0);
    end

    // random mix of lookups, host traffic and mode changes (R3-R10)
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 4) != 0;
      bit we = ($urandom % 3) == 0;
      logic [7:0] p = 8'($urandom);
      logic [9:0] a = (($urandom % 4) == 0) ? {p, 2'($urandom)} : 10'($urandom);
      cyc(v, p, 1'($urandom), we, a, 26'($urandom));
    end

    cyc(1'b0, 8'hff, 1'b1, 1'b0, '0, '0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end
endmodule